// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory port. A new external address is captured whenever an address strobe is accepted. After that, the block generates the low burst bits of each following beat by itself. There are two strobes. The controller strobe is always accepted. The processor strobe is accepted only while chip enable is high.

An advance input steps the burst by one beat, and the burst wraps after four beats. With no strobe and no advance, the address holds. A static strap selects the beat order, either linear (count up and wrap) or interleaved (XOR with the beat number).

Bursts are optional. A fresh address may be strobed on every cycle, and each one reaches the output one clock later.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `addr_out` is zero.
- R2: When `ctrl_strobe` is high at a clock edge, `addr_out` equals the `addr_in` captured at that edge, starting from that edge. This holds whatever the state of `chip_en`.
- R3: When `proc_strobe` is high at a clock edge and `chip_en` is high, the address is loaded exactly as in R2. When `chip_en` is low, `proc_strobe` has no effect and `addr_out` keeps its value.
- R4: An accepted strobe wins over `advance`. The edge loads `addr_in` and restarts the beat count at 0.
- R5: With `interleave_mode` = 0 (linear), the low two bits after n advances are (loaded low bits + n) mod 4. Starting at 1, this gives 1, 2, 3, 0.
- R6: With `interleave_mode` = 1 (interleaved), the low two bits after n advances are the loaded low bits XOR (n mod 4). Starting at 1, this gives 1, 0, 3, 2.
- R7: With no accepted strobe and `advance` low, `addr_out` holds its value.
- R8: Bits above the low two keep the loaded value through a whole burst. After four advances, the address returns to the loaded address in both orders.
- R9: Strobes on consecutive cycles each load their own address, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enable; gates the processor strobe |
| proc_strobe | input | 1 | Processor address strobe |
| ctrl_strobe | input | 1 | Controller address strobe; accepted whatever the state of chip_en |
| advance | input | 1 | Step the burst by one beat |
| interleave_mode | input | 1 | Beat order: 0 = linear, 1 = interleaved |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with `ADDR_W` = 12 and `BURST_W` = 2. This keeps the upper field small enough that random addresses often repeat upper bits across reloads, while the burst field still has its full four-beat wrap.

Directed sequences start a burst from each of the four low offsets in both orders and run five advances, so every case crosses the wrap. Random cycles then mix the two strobes, chip enable, advance, hold and order changes against a reference model in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        BS_HOLD = 2'd0,
        BS_LOAD = 2'd1,
        BS_STEP = 2'd2
    } bs_cmd_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bs_order_e;

    typedef struct packed {
        logic ce;
        logic ps;
        logic cs;
        logic adv;
    } bs_ctl_s;

    // A strobe outranks advance; the processor strobe needs chip enable.
    function automatic bs_cmd_e bs_decode(bs_ctl_s c);
        if (c.cs || (c.ps && c.ce)) return BS_LOAD;
        if (c.adv)                  return BS_STEP;
        return BS_HOLD;
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  bs_ctl_s ctl,
    output bs_cmd_e cmd
);
    always_comb cmd = bs_decode(ctl);
endmodule

// File: rtl/burst_addr_regs.sv
module burst_addr_regs
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bs_cmd_e           cmd,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] base_q,
    output logic [BURST_W-1:0] beat_q
);
    localparam logic [BURST_W-1:0] BEAT_ONE = BURST_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            unique case (cmd)
                BS_LOAD: begin
                    base_q <= load_addr;
                    beat_q <= '0;
                end
                BS_STEP: beat_q <= beat_q + BEAT_ONE;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  bs_order_e          order,
    input  logic [BURST_W-1:0] start_low,
    input  logic [BURST_W-1:0] beat,
    output logic [BURST_W-1:0] low
);
    logic [BURST_W-1:0] lin_low;
    logic [BURST_W-1:0] ilv_low;

    assign lin_low = start_low + beat;

    for (genvar i = 0; i < BURST_W; i++) begin : g_xor
        assign ilv_low[i] = start_low[i] ^ beat[i];
    end

    assign low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              advance,
    input  logic              interleave_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    bs_ctl_s            ctl;
    bs_cmd_e            cmd;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] beat_q;
    logic [BURST_W-1:0] low;
    bs_order_e          order;

    assign ctl   = '{ce: chip_en, ps: proc_strobe, cs: ctrl_strobe, adv: advance};
    assign order = bs_order_e'(interleave_mode);

    burst_cmd_decode i_dec (
        .ctl (ctl),
        .cmd (cmd)
    );

    burst_addr_regs #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .load_addr (addr_in),
        .base_q    (base_q),
        .beat_q    (beat_q)
    );

    burst_order_map #(.BURST_W(BURST_W)) i_map (
        .order     (order),
        .start_low (base_q[BURST_W-1:0]),
        .beat      (beat_q),
        .low       (low)
    );

    assign addr_out = {base_q[ADDR_W-1 -: UPPER_W], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_en,
    input logic              proc_strobe,
    input logic              ctrl_strobe,
    input logic              advance,
    input logic              interleave_mode,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

    logic               take;
    logic [BURST_W-1:0] low_inc;

    assign take    = ctrl_strobe || (proc_strobe && chip_en);
    assign low_inc = addr_out[BURST_W-1:0] + ONE;

    // R2, R3, R4, R9: an accepted strobe shows the loaded address one edge later
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> addr_out == $past(addr_in));

    // R3, R7: a processor strobe without chip enable changes nothing
    p_ps_gated_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_strobe && !advance && !chip_en) |=>
            (interleave_mode != $past(interleave_mode)) || addr_out == $past(addr_out));

    // R5: linear order steps the low bits by one with wrap
    p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
        (advance && !take && !interleave_mode) |=>
            interleave_mode || addr_out[BURST_W-1:0] == $past(low_inc));

    // R8: upper bits stay fixed without a load
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        !take |=> addr_out[ADDR_W-1:BURST_W] == $past(addr_out[ADDR_W-1:BURST_W]));

    // R7: no strobe and no advance holds the address
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!take && !advance) |=>
            (interleave_mode != $past(interleave_mode)) || addr_out == $past(addr_out));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_chk (.*);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int AW = 12;
    localparam int BW = 2;
    localparam int BEATS = 1 << BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_en = 1'b0, proc_strobe = 1'b0, ctrl_strobe = 1'b0;
    logic          advance = 1'b0, interleave_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int total = 0;
    int bad   = 0;

    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) i_burst_addr_seq (
        .clk(clk), .rst(rst), .chip_en(chip_en), .proc_strobe(proc_strobe),
        .ctrl_strobe(ctrl_strobe), .advance(advance),
        .interleave_mode(interleave_mode), .addr_in(addr_in), .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] base, int beat, logic ilv);
        logic [BW-1:0] lo;
        logic [BW-1:0] b;
        b  = BW'(beat);
        lo = ilv ? (base[BW-1:0] ^ b) : BW'(base[BW-1:0] + b);
        return {base[AW-1:BW], lo};
    endfunction

    task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cyc(string tag, logic ce, logic ps, logic cs, logic adv,
                       logic ilv, logic [AW-1:0] a);
        @(negedge clk);
        chip_en = ce; proc_strobe = ps; ctrl_strobe = cs;
        advance = adv; interleave_mode = ilv; addr_in = a;
        @(posedge clk);
        if (cs || (ps && ce)) begin
            m_base = a;
            m_beat = 0;
        end else if (adv) begin
            m_beat = (m_beat + 1) % BEATS;
        end
        #2;
        check(tag, addr_out, expect_addr(m_base, m_beat, ilv));
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #2;
        check("R1 in reset", addr_out, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1 after reset", addr_out, '0);

        // R5, R6, R8: every start offset in both orders, past the wrap
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int off = 0; off < BEATS; off++) begin
                logic [AW-1:0] a;
                a = {10'h2A5 + 10'(off * 3), 2'(off)};
                cyc("R2 load", 1'b0, 1'b0, 1'b1, 1'b0, 1'(ilv), a);
                for (int s = 0; s < BEATS; s++)
                    cyc(ilv ? "R6 interleave" : "R5 linear", 1'b0, 1'b0, 1'b0, 1'b1, 1'(ilv), '0);
                check("R8 wrap to start", addr_out, a);
                cyc("R8 next after wrap", 1'b0, 1'b0, 1'b0, 1'b1, 1'(ilv), '0);
            end
        end

        // R7: hold
        cyc("R3 load via proc", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h5C1);
        cyc("R5 step", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'hFFF);
        repeat (3) cyc("R7 hold", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h333);
        check("R7 held value", addr_out, 12'h5C2);

        // R3: proc strobe ignored without chip enable
        cyc("R3 ignored", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h0AA);
        check("R3 ignored value", addr_out, 12'h5C2);

        // R4: strobe beats advance
        cyc("R4 priority", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h7F3);
        check("R4 priority value", addr_out, 12'h7F3);

        // R2 with chip enable low, R9 back to back
        cyc("R9 b2b", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h101);
        cyc("R9 b2b", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h202);
        cyc("R9 b2b", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h303);
        check("R9 last value", addr_out, 12'h303);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic ce, ps, cs, adv, ilv;
            string tag;
            ce  = 1'($urandom % 2);
            ps  = ($urandom % 4) == 0;
            cs  = ($urandom % 6) == 0;
            adv = ($urandom % 3) != 0;
            ilv = ($urandom % 16) < 7;
            if (cs)            tag = "R2 rand";
            else if (ps && ce) tag = "R3 rand";
            else if (adv)      tag = ilv ? "R6 rand" : "R5 rand";
            else               tag = "R7 rand";
            cyc(tag, ce, ps, cs, adv, ilv, AW'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule